// File: doc/BRIEF.md
# Sync-Headed Command Packet Receiver

This block watches a byte stream that arrives one byte per cycle in which `rx_valid` is high. It looks for a fixed three-byte sync pattern, then collects a command code, a little-endian address and a little-endian length, and verifies a header checksum. The checksum is an XOR seeded with 0x81. A header that passes is reported with a one-cycle `cmd_valid` pulse, and the decoded fields are presented on `cmd_code`, `cmd_addr` and `cmd_len` in that cycle. A header that fails raises a one-cycle `hdr_err` pulse instead.

Two codes are upload commands. After one of them, the receiver enters a payload phase. It echoes each of the next `length` bytes on `pay_strobe`/`pay_data`, folds them into a fresh 0x81-seeded XOR, and compares the byte that follows with that XOR. The result comes out as a one-cycle `pay_ok` or `pay_err` pulse. After that, or after any non-upload command, the receiver goes back to hunting for sync. Carrying out the commands is left to the logic around the block.

Top module: `cmd_packet_rx`

## Requirements
- R1: After reset every strobe output (`cmd_valid`, `hdr_err`, `pay_strobe`, `pay_ok`, `pay_err`) is low and the receiver is hunting for sync.
- R2: Field collection starts only after the bytes 0xD5, 0xAA, 0x96 have arrived consecutively. A stream without that sequence produces no strobe.
- R3: A byte that breaks the sync sequence restarts the hunt. If that byte is 0xD5, it counts as the first sync byte, so D5 D5 AA 96 and D5 AA D5 AA 96 both synchronise.
- R4: The byte after the sync is the command code. The next two bytes are the address, least significant byte first. The next two are the length, least significant byte first. All three fields are valid on the outputs while `cmd_valid` is high.
- R5: The ninth byte of a packet is the header checksum, equal to 0x81 XOR all eight preceding bytes. If it matches and the code is 0x00 to 0x05, `cmd_valid` is high for exactly the one cycle after the edge that accepted the checksum byte.
- R6: On a header checksum mismatch, `hdr_err` pulses for one cycle in place of `cmd_valid`. The receiver returns to sync hunting, and the bytes that follow are not treated as payload.
- R7: A command code above 0x05 raises `hdr_err` even when its checksum is correct.
- R8: After a valid upload command (code 0x00 memory upload or 0x02 video RAM upload) with length N > 0, each of the next N accepted bytes appears on `pay_data` with `pay_strobe` high in the following cycle.
- R9: The byte after the payload is the payload checksum, compared with 0x81 XOR the payload bytes. A match pulses `pay_ok` and a mismatch pulses `pay_err`, one cycle after that byte. The receiver then hunts for sync.
- R10: An upload with length zero expects the payload checksum byte directly. That byte must be 0x81.
- R11: Valid non-upload commands (0x01, 0x03, 0x04, 0x05) return the receiver to sync hunting immediately, so the bytes that follow produce no payload strobes.
- R12: Cycles with `rx_valid` low change nothing. Idle gaps between bytes of a packet do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Qualifies `rx_byte` for this cycle |
| rx_byte | input | 8 | Received byte |
| cmd_valid | output | 1 | One-cycle pulse: a header was accepted |
| cmd_code | output | 8 | Command code of the last header |
| cmd_addr | output | 16 | Address field (default 2 bytes) |
| cmd_len | output | 16 | Length field (default 2 bytes) |
| hdr_err | output | 1 | One-cycle pulse: bad header checksum or unknown code |
| pay_strobe | output | 1 | One-cycle pulse per payload byte |
| pay_data | output | 8 | Payload byte qualified by `pay_strobe` |
| pay_ok | output | 1 | One-cycle pulse: payload checksum matched |
| pay_err | output | 1 | One-cycle pulse: payload checksum mismatched |

## Verification
The bench builds the receiver with its default parameters: a three-byte 0xD5 0xAA 0x96 sync, a 0x81 seed, two-byte address and length fields, codes up to 0x05, and uploads on 0x00 and 0x02. With these values, lengths of zero and a few bytes are quick to reach, and so are the restart cases in which 0xD5 reappears mid-sync. Because the length is sent least significant byte first, a byte-order error turns a three-byte payload into one of 768 bytes, and the per-cycle comparison against the behavioural model exposes that at once. Lengths near the 16-bit limit are not exercised.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_HUNT,
      ST_FIELD,
      ST_HSUM,
      ST_PAY,
      ST_PSUM
   } rx_state_e;

   typedef enum logic [1:0] {
      ACC_HOLD,
      ACC_SEED,
      ACC_START,
      ACC_FOLD
   } acc_op_e;

endpackage

// File: rtl/cmdrx_sync_match.sv
module cmdrx_sync_match #(
   parameter int          SYNC_LEN = 3,
   parameter logic [31:0] SYNC_PAT = 32'h00D5_AA96,
   parameter int          IDX_W    = 2
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       data,
   output logic             hit,
   output logic             first_hit,
   output logic             last
);
   logic [7:0] pat [SYNC_LEN];

   for (genvar g = 0; g < SYNC_LEN; g++) begin : g_pat
      assign pat[g] = SYNC_PAT[8*(SYNC_LEN-1-g) +: 8];
   end

   always_comb begin
      hit = 1'b0;
      for (int k = 0; k < SYNC_LEN; k++) begin
         if (idx == IDX_W'(k)) hit = (data == pat[k]);
      end
   end

   assign first_hit = (data == pat[0]);
   assign last      = (idx == IDX_W'(SYNC_LEN-1));
endmodule

// File: rtl/cmdrx_xor_acc.sv
module cmdrx_xor_acc
   import cmdrx_pkg::*;
#(
   parameter logic [7:0] SEED = 8'h81
) (
   input  logic       clk,
   input  logic       rst_n,
   input  acc_op_e    op,
   input  logic [7:0] data,
   output logic [7:0] acc
);
   always_ff @(posedge clk) begin
      if (!rst_n) acc <= SEED;
      else begin
         unique case (op)
            ACC_SEED:  acc <= SEED;
            ACC_START: acc <= SEED ^ data;
            ACC_FOLD:  acc <= acc ^ data;
            default:   acc <= acc;
         endcase
      end
   end
endmodule

// File: rtl/cmdrx_down_cnt.sv
module cmdrx_down_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         is_one
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (dec)  cnt_q <= cnt_q - 1'b1;
   end

   assign is_one = (cnt_q == W'(1));
endmodule

// File: rtl/cmd_packet_rx.sv
module cmd_packet_rx
   import cmdrx_pkg::*;
#(
   parameter int          SYNC_LEN    = 3,
   parameter logic [31:0] SYNC_PAT    = 32'h00D5_AA96,
   parameter logic [7:0]  CSUM_SEED   = 8'h81,
   parameter int          ADDR_BYTES  = 2,
   parameter int          LEN_BYTES   = 2,
   parameter int          LAST_CMD    = 5,
   parameter logic [15:0] UPLOAD_MASK = 16'h0005,
   localparam int         AW          = 8 * ADDR_BYTES,
   localparam int         LW          = 8 * LEN_BYTES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [7:0]    rx_byte,
   output logic          cmd_valid,
   output logic [7:0]    cmd_code,
   output logic [AW-1:0] cmd_addr,
   output logic [LW-1:0] cmd_len,
   output logic          hdr_err,
   output logic          pay_strobe,
   output logic [7:0]    pay_data,
   output logic          pay_ok,
   output logic          pay_err
);
   localparam int IDX_W    = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;
   localparam int FLD_CNT  = 1 + ADDR_BYTES + LEN_BYTES;
   localparam int FLD_W    = $clog2(FLD_CNT + 1);

   if (SYNC_LEN < 1 || SYNC_LEN > 4) begin : g_bad_sync
      $error("cmd_packet_rx: SYNC_LEN must be 1..4");
   end
   if (ADDR_BYTES < 1 || LEN_BYTES < 1) begin : g_bad_field
      $error("cmd_packet_rx: field widths must be at least one byte");
   end
   if (LAST_CMD < 0 || LAST_CMD > 15) begin : g_bad_cmd
      $error("cmd_packet_rx: LAST_CMD must be 0..15");
   end

   rx_state_e         state_q, state_d;
   logic [IDX_W-1:0]  sync_q, sync_d;
   logic [FLD_W-1:0]  fld_q, fld_d;
   logic [7:0]        code_q, code_d;
   logic [AW-1:0]     addr_q, addr_d;
   logic [LW-1:0]     len_q, len_d;
   logic              cmd_v_d, herr_d, pstb_d, pok_d, perr_d;
   acc_op_e           acc_op;
   logic [7:0]        acc;
   logic              cnt_load, cnt_dec, cnt_one;
   logic              s_hit, s_first, s_last;
   logic              code_known, is_upload;

   cmdrx_sync_match #(.SYNC_LEN(SYNC_LEN), .SYNC_PAT(SYNC_PAT), .IDX_W(IDX_W)) u_sync (
      .idx(sync_q), .data(rx_byte), .hit(s_hit), .first_hit(s_first), .last(s_last)
   );

   cmdrx_xor_acc #(.SEED(CSUM_SEED)) u_acc (
      .clk(clk), .rst_n(rst_n), .op(acc_op), .data(rx_byte), .acc(acc)
   );

   cmdrx_down_cnt #(.W(LW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(len_q),
      .dec(cnt_dec), .is_one(cnt_one)
   );

   assign code_known = ({24'd0, code_q} <= 32'(LAST_CMD));
   assign is_upload  = UPLOAD_MASK[code_q[3:0]];

   always_comb begin
      state_d  = state_q;
      sync_d   = sync_q;
      fld_d    = fld_q;
      code_d   = code_q;
      addr_d   = addr_q;
      len_d    = len_q;
      acc_op   = ACC_HOLD;
      cnt_load = 1'b0;
      cnt_dec  = 1'b0;
      cmd_v_d  = 1'b0;
      herr_d   = 1'b0;
      pstb_d   = 1'b0;
      pok_d    = 1'b0;
      perr_d   = 1'b0;
      if (rx_valid) begin
         unique case (state_q)
            ST_HUNT: begin
               if (s_hit) begin
                  acc_op = (sync_q == '0) ? ACC_START : ACC_FOLD;
                  if (s_last) begin
                     state_d = ST_FIELD;
                     sync_d  = '0;
                     fld_d   = '0;
                  end else begin
                     sync_d = IDX_W'(sync_q + 1'b1);
                  end
               end else if (s_first) begin
                  acc_op = ACC_START;
                  sync_d = IDX_W'(1);
               end else begin
                  sync_d = '0;
               end
            end
            ST_FIELD: begin
               acc_op = ACC_FOLD;
               if (fld_q == '0)
                  code_d = rx_byte;
               else if (fld_q <= FLD_W'(ADDR_BYTES))
                  addr_d = (addr_q >> 8) | (AW'(rx_byte) << (AW - 8));
               else
                  len_d = (len_q >> 8) | (LW'(rx_byte) << (LW - 8));
               if (fld_q == FLD_W'(FLD_CNT - 1)) state_d = ST_HSUM;
               else fld_d = FLD_W'(fld_q + 1'b1);
            end
            ST_HSUM: begin
               state_d = ST_HUNT;
               if (rx_byte == acc && code_known) begin
                  cmd_v_d = 1'b1;
                  if (is_upload) begin
                     acc_op = ACC_SEED;
                     if (len_q == '0) state_d = ST_PSUM;
                     else begin
                        cnt_load = 1'b1;
                        state_d  = ST_PAY;
                     end
                  end
               end else begin
                  herr_d = 1'b1;
               end
            end
            ST_PAY: begin
               pstb_d  = 1'b1;
               acc_op  = ACC_FOLD;
               cnt_dec = 1'b1;
               if (cnt_one) state_d = ST_PSUM;
            end
            ST_PSUM: begin
               if (rx_byte == acc) pok_d = 1'b1;
               else perr_d = 1'b1;
               state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_HUNT;
         sync_q     <= '0;
         fld_q      <= '0;
         code_q     <= '0;
         addr_q     <= '0;
         len_q      <= '0;
         cmd_valid  <= 1'b0;
         hdr_err    <= 1'b0;
         pay_strobe <= 1'b0;
         pay_data   <= '0;
         pay_ok     <= 1'b0;
         pay_err    <= 1'b0;
      end else begin
         state_q    <= state_d;
         sync_q     <= sync_d;
         fld_q      <= fld_d;
         code_q     <= code_d;
         addr_q     <= addr_d;
         len_q      <= len_d;
         cmd_valid  <= cmd_v_d;
         hdr_err    <= herr_d;
         pay_strobe <= pstb_d;
         pay_ok     <= pok_d;
         pay_err    <= perr_d;
         if (pstb_d) pay_data <= rx_byte;
      end
   end

   assign cmd_code = code_q;
   assign cmd_addr = addr_q;
   assign cmd_len  = len_q;
endmodule

// File: rtl/cmd_packet_rx_chk.sv
module cmd_packet_rx_chk #(
   parameter int AW       = 16,
   parameter int LW       = 16,
   parameter int LAST_CMD = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_valid,
   input logic          cmd_valid,
   input logic [7:0]    cmd_code,
   input logic [AW-1:0] cmd_addr,
   input logic [LW-1:0] cmd_len,
   input logic          hdr_err,
   input logic          pay_strobe,
   input logic          pay_ok,
   input logic          pay_err
);
   // R5/R6: accept and reject are never reported together
   p_accept_xor_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && hdr_err));

   // R5: the accept pulse lasts a single cycle
   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R7: an accepted header always carries a known code
   p_known_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> ({24'd0, cmd_code} <= 32'(LAST_CMD)));

   // R4: fields do not move on the checksum byte edge
   p_fields_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> ($stable(cmd_code) && $stable(cmd_addr) && $stable(cmd_len)));

   // R9: payload events are mutually exclusive
   p_pay_events_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pay_strobe, pay_ok, pay_err}));

   // R12: every event follows an accepted byte
   p_needs_byte_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid || hdr_err || pay_strobe || pay_ok || pay_err) |-> $past(rx_valid));
endmodule

bind cmd_packet_rx cmd_packet_rx_chk #(.AW(AW), .LW(LW), .LAST_CMD(LAST_CMD)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .cmd_valid(cmd_valid),
   .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .hdr_err(hdr_err),
   .pay_strobe(pay_strobe), .pay_ok(pay_ok), .pay_err(pay_err)
);

// File: tb/cmd_packet_rx_tb_top.sv
module cmd_packet_rx_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        cmd_valid, hdr_err, pay_strobe, pay_ok, pay_err;
   logic [7:0]  cmd_code, pay_data;
   logic [15:0] cmd_addr, cmd_len;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_packet_rx dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
      .hdr_err(hdr_err), .pay_strobe(pay_strobe), .pay_data(pay_data),
      .pay_ok(pay_ok), .pay_err(pay_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   byte unsigned sync_seq [3] = '{8'hD5, 8'hAA, 8'h96};
   int           m_mode = 0;     // 0 hunt, 1 header, 2 payload, 3 payload checksum
   int           m_matched = 0;
   byte unsigned m_hdr [$];
   int           m_left = 0;
   byte unsigned m_pacc = 8'h81;
   bit           e_cmd, e_herr, e_pstb, e_pok, e_perr;
   byte unsigned e_pdata, e_code;
   int           e_addr, e_len;

   always @(posedge clk) begin
      e_cmd = 0; e_herr = 0; e_pstb = 0; e_pok = 0; e_perr = 0;
      if (!rst_n) begin
         m_mode = 0; m_matched = 0; m_hdr.delete();
      end else if (rx_valid) begin
         byte unsigned b;
         b = rx_byte;
         case (m_mode)
            0: begin
               if (b == sync_seq[m_matched]) begin
                  m_matched++;
                  if (m_matched == 3) begin
                     m_mode = 1; m_matched = 0; m_hdr.delete();
                  end
               end else m_matched = (b == 8'hD5) ? 1 : 0;
            end
            1: begin
               m_hdr.push_back(b);
               if (m_hdr.size() == 6) begin
                  byte unsigned s;
                  s = 8'h81 ^ 8'hD5 ^ 8'hAA ^ 8'h96;
                  for (int i = 0; i < 5; i++) s ^= m_hdr[i];
                  m_mode = 0;
                  if (s == m_hdr[5] && m_hdr[0] <= 5) begin
                     e_cmd  = 1;
                     e_code = m_hdr[0];
                     e_addr = m_hdr[1] + 256 * m_hdr[2];
                     e_len  = m_hdr[3] + 256 * m_hdr[4];
                     if (e_code == 0 || e_code == 2) begin
                        m_pacc = 8'h81;
                        m_left = e_len;
                        m_mode = (e_len == 0) ? 3 : 2;
                     end
                  end else e_herr = 1;
               end
            end
            2: begin
               e_pstb = 1; e_pdata = b; m_pacc ^= b; m_left--;
               if (m_left == 0) m_mode = 3;
            end
            default: begin
               if (b == m_pacc) e_pok = 1; else e_perr = 1;
               m_mode = 0;
            end
         endcase
      end
   end

   // ---------------- per-cycle comparison and event counters ----------------
   int n_cmd = 0, n_herr = 0, n_pstb = 0, n_pok = 0, n_perr = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         check(cmd_valid == e_cmd, "R5", "cmd_valid", cmd_valid, e_cmd);
         if (e_cmd) begin
            check(cmd_code == e_code, "R4", "cmd_code", cmd_code, e_code);
            check(cmd_addr == e_addr[15:0], "R4", "cmd_addr", cmd_addr, e_addr);
            check(cmd_len == e_len[15:0], "R4", "cmd_len", cmd_len, e_len);
         end
         check(hdr_err == e_herr, "R6", "hdr_err", hdr_err, e_herr);
         check(pay_strobe == e_pstb, "R8", "pay_strobe", pay_strobe, e_pstb);
         if (e_pstb) check(pay_data == e_pdata, "R8", "pay_data", pay_data, e_pdata);
         check(pay_ok == e_pok, "R9", "pay_ok", pay_ok, e_pok);
         check(pay_err == e_perr, "R9", "pay_err", pay_err, e_perr);
         n_cmd  += cmd_valid;
         n_herr += hdr_err;
         n_pstb += pay_strobe;
         n_pok  += pay_ok;
         n_perr += pay_err;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic send_byte(input byte unsigned b, input int gap);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
      rx_byte  = 8'h5A;
      repeat (gap) @(negedge clk);
   endtask

   task automatic send_hdr(input byte unsigned code, input int addr, input int len,
                           input bit corrupt, input int gap);
      byte unsigned f [6];
      byte unsigned s;
      f[0] = code; f[1] = addr[7:0]; f[2] = addr[15:8];
      f[3] = len[7:0]; f[4] = len[15:8];
      s = 8'h81 ^ 8'hD5 ^ 8'hAA ^ 8'h96;
      for (int i = 0; i < 5; i++) s ^= f[i];
      f[5] = corrupt ? (s ^ 8'h10) : s;
      send_byte(8'hD5, gap); send_byte(8'hAA, gap); send_byte(8'h96, gap);
      for (int i = 0; i < 6; i++) send_byte(f[i], gap);
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   int c0, h0, p0, k0, x0;
   task automatic snap();
      c0 = n_cmd; h0 = n_herr; p0 = n_pstb; k0 = n_pok; x0 = n_perr;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check({cmd_valid, hdr_err, pay_strobe, pay_ok, pay_err} == 5'b0, "R1", "strobes in reset",
            {cmd_valid, hdr_err, pay_strobe, pay_ok, pay_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({cmd_valid, hdr_err, pay_strobe, pay_ok, pay_err} == 5'b0, "R1", "strobes after reset",
            {cmd_valid, hdr_err, pay_strobe, pay_ok, pay_err}, 0);

      // R2: no sync sequence, no events
      snap();
      foreach (sync_seq[i]) send_byte(sync_seq[2-i], 0);
      for (int i = 0; i < 16; i++) send_byte(byte'(8'h11 * i), 0);
      send_byte(8'hD5, 0); send_byte(8'h96, 0); send_byte(8'hAA, 0);
      settle();
      check((n_cmd + n_herr + n_pstb + n_pok + n_perr) == (c0 + h0 + p0 + k0 + x0),
            "R2", "events without sync", n_cmd + n_herr - c0 - h0, 0);

      // R4/R5: plain download header
      snap();
      send_hdr(8'h01, 16'h1234, 16'h0010, 0, 0);
      settle();
      check(n_cmd == c0 + 1, "R5", "download accepted", n_cmd - c0, 1);

      // R3: repeated first sync byte, then broken sync restarting on 0xD5
      snap();
      send_byte(8'hD5, 0);
      send_hdr(8'h04, 16'hC000, 0, 0, 0);
      settle();
      check(n_cmd == c0 + 1, "R3", "D5 D5 AA 96 sync", n_cmd - c0, 1);
      snap();
      send_byte(8'hD5, 0); send_byte(8'hAA, 0);
      send_hdr(8'h03, 16'h8001, 16'h0002, 0, 0);
      settle();
      check(n_cmd == c0 + 1, "R3", "D5 AA D5 AA 96 sync", n_cmd - c0, 1);

      // R6: bad header checksum, following bytes are not payload
      snap();
      send_hdr(8'h00, 16'hC100, 16'h0002, 1, 0);
      send_byte(8'h01, 0); send_byte(8'h02, 0); send_byte(8'h82, 0);
      settle();
      check(n_herr == h0 + 1 && n_cmd == c0, "R6", "bad checksum error", n_herr - h0, 1);
      check(n_pstb == p0 && n_pok == k0 && n_perr == x0, "R6", "no payload after error",
            n_pstb - p0, 0);

      // R7: unknown code with good checksum
      snap();
      send_hdr(8'h06, 16'h0000, 16'h0000, 0, 0);
      settle();
      check(n_herr == h0 + 1 && n_cmd == c0, "R7", "unknown code error", n_herr - h0, 1);

      // R8/R9: memory upload, three bytes, good payload checksum
      snap();
      send_hdr(8'h00, 16'hC200, 16'h0003, 0, 0);
      send_byte(8'h11, 0); send_byte(8'h22, 0); send_byte(8'h33, 0);
      send_byte(8'h81 ^ 8'h11 ^ 8'h22 ^ 8'h33, 0);
      settle();
      check(n_pstb == p0 + 3, "R8", "payload byte count", n_pstb - p0, 3);
      check(n_pok == k0 + 1, "R9", "payload checksum ok", n_pok - k0, 1);

      // R9: video upload with wrong payload checksum
      snap();
      send_hdr(8'h02, 16'h4000, 16'h0002, 0, 0);
      send_byte(8'hA0, 0); send_byte(8'h0B, 0); send_byte(8'h00, 0);
      settle();
      check(n_perr == x0 + 1 && n_pok == k0, "R9", "payload checksum error", n_perr - x0, 1);

      // R10: zero-length upload expects only the checksum 0x81
      snap();
      send_hdr(8'h00, 16'hD000, 16'h0000, 0, 0);
      send_byte(8'h81, 0);
      settle();
      check(n_pok == k0 + 1 && n_pstb == p0, "R10", "zero length checksum", n_pok - k0, 1);

      // R11: set-page command followed by bytes that would close a payload
      snap();
      send_hdr(8'h05, 16'h0042, 16'h0000, 0, 0);
      send_byte(8'h81, 0); send_byte(8'h00, 0);
      settle();
      check(n_cmd == c0 + 1 && n_pstb == p0 && n_pok == k0 && n_perr == x0,
            "R11", "no payload after non-upload", n_pok + n_perr - k0 - x0, 0);

      // R12: idle gaps inside an upload
      snap();
      send_hdr(8'h00, 16'h0102, 16'h0002, 0, 3);
      send_byte(8'h7E, 2); send_byte(8'hE7, 5);
      send_byte(8'h81 ^ 8'h7E ^ 8'hE7, 1);
      settle();
      check(n_cmd == c0 + 1 && n_pstb == p0 + 2 && n_pok == k0 + 1, "R12",
            "packet with idle gaps", n_pok - k0, 1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule